// File: doc/BRIEF.md
# Nibble-Wide Memory CPU Access Sequencer

This block gives an 8-bit processor byte access to a memory that stores 4-bit nibbles. The memory is addressed through a multiplexed row/column interface with active-low strobes. Time on the memory is divided into fixed-length access slots. Before each slot starts, a video fetch engine states whether it owns that slot. Video slots use the video address and always run in read mode. Every other slot belongs to the processor.

The block does not receive a processor clock. It generates one from the processor slots, and the level of that clock toggles at the end of each processor slot. On the falling edge of the generated clock the block latches the processor address and direction. The processor slot that follows (clock low) reads the addressed byte as two nibbles. On the rising edge the assembled byte is handed to the processor on a read, or the processor's write byte is captured on a write. The next processor slot (clock high) then writes a captured byte into memory as two nibbles, high nibble first.

Top module: `nibram_cpu_seq`

## Requirements
- R1: A slot lasts SLOT_LEN clock cycles (default 8), counted 0 to SLOT_LEN-1. ram_ras_n is low in cycles 0 to 3. ram_cas_n is low in cycles 1 and 3 only. All strobes are active low.
- R2: The nibble address is {byte address, half}. Half is 0 at the first column strobe and 1 at the second, so the high nibble sits at the even location. ram_row carries the nibble address above the low COL_W bits, and ram_col carries the low COL_W bits. The row stays constant while ram_ras_n is low.
- R3: In a write slot, ram_wdata carries byte bits 7:4 at the first column strobe and bits 3:0 at the second. Writing a byte and later reading the same address returns that byte.
- R4: In a read, the nibble fetched at the first column strobe becomes bits 7:4 of the assembled byte. The nibble fetched at the second column strobe becomes bits 3:0.
- R5: In a video-owned slot, the row and column come from vid_addr using the R2 mapping. ram_we_n stays high for the whole slot, and memory contents are unchanged.
- R6: ram_we_n goes low (cycles 1 to 3) only in a processor slot while cpu_clk is high and the latched direction is write (cpu_rnw=0). Every other slot runs in read mode.
- R7: cpu_clk toggles at the end of each processor-owned slot and holds its level through video-owned slots. The vid_own value present in a slot's last cycle decides ownership of the next slot. After reset, the first slot's owner is taken from vid_own on the first cycle after reset release.
- R8: When cpu_clk rises and the latched direction is read, cpu_rdata takes the assembled byte. cpu_rdata changes at no other time. When cpu_clk rises and the latched direction is write, cpu_wdata is captured as the byte to store.
- R9: cpu_addr and cpu_rnw are sampled only when cpu_clk falls. Changes to them between falls have no effect on the access in progress.
- R10: During reset, cpu_clk is low and ram_ras_n, ram_cas_n and ram_we_n are high. The latched request resets to a read of address 0, so the first rising cpu_clk delivers the byte at address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory-side clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| vid_own | input | 1 | High in a slot's last cycle when video takes the next slot |
| vid_addr | input | AW | Byte address used by a video slot |
| cpu_addr | input | AW | Processor byte address |
| cpu_rnw | input | 1 | Processor direction, 1 = read, 0 = write |
| cpu_wdata | input | 2*NW | Processor write byte |
| cpu_rdata | output | 2*NW | Byte returned to the processor |
| cpu_clk | output | 1 | Generated processor clock |
| ram_row | output | AW+1-COL_W | Row part of the nibble address |
| ram_col | output | COL_W | Column part of the nibble address |
| ram_ras_n | output | 1 | Row strobe, active low |
| ram_cas_n | output | 1 | Column strobe, active low |
| ram_we_n | output | 1 | Write enable, active low |
| ram_wdata | output | NW | Nibble driven to memory |
| ram_rdata | input | NW | Nibble returned by memory |

## Verification
The properties assume the memory returns ram_rdata combinationally for the address currently on ram_row and ram_col. They also assume the processor holds cpu_wdata from the fall of cpu_clk until its next rise. The bench's memory model and processor model follow both rules. The processor model scrambles cpu_addr and cpu_rnw right after each fall, because the design must ignore them at that point. Slot ownership is drawn from $urandom in the middle of each slot, so vid_own is steady through every slot's last cycle. Stimulus phases range from no video at all to runs in which video owns every slot.

// File: rtl/nibseq_pkg.sv
package nibseq_pkg;

  // Position inside an access slot; every cycle past the low column is rest.
  typedef enum logic [2:0] {
    PH_ROW  = 3'd0,
    PH_HI   = 3'd1,
    PH_GAP  = 3'd2,
    PH_LO   = 3'd3,
    PH_REST = 3'd4
  } phase_e;

  // Shortest legal slot: row, hi, gap, lo, one rest cycle, slot end.
  localparam int unsigned SLOT_MIN = 6;

endpackage

// File: rtl/nibseq_slot_timer.sv
module nibseq_slot_timer
  import nibseq_pkg::*;
#(
  parameter int unsigned SLOT_LEN = 8
) (
  input  logic   clk,
  input  logic   rst_n,
  output phase_e phase,
  output logic   slot_end
);

  localparam int unsigned CW   = (SLOT_LEN > 1) ? $clog2(SLOT_LEN) : 1;
  localparam logic [CW-1:0] LAST = CW'(SLOT_LEN - 1);

  logic [CW-1:0] cyc_q;
  logic [CW-1:0] cyc_d;

  always_comb begin
    slot_end = (cyc_q == LAST);
    cyc_d    = slot_end ? '0 : cyc_q + CW'(1);
  end

  always_comb begin
    if      (cyc_q == CW'(0)) phase = PH_ROW;
    else if (cyc_q == CW'(1)) phase = PH_HI;
    else if (cyc_q == CW'(2)) phase = PH_GAP;
    else if (cyc_q == CW'(3)) phase = PH_LO;
    else                      phase = PH_REST;
  end

  // Reset parks the counter on the last cycle so strobes are idle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cyc_q <= LAST;
    else        cyc_q <= cyc_d;
  end

endmodule

// File: rtl/nibseq_cpu_phase.sv
module nibseq_cpu_phase #(
  parameter int unsigned AW = 16,
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          slot_end,
  input  logic          vid_own,
  input  logic [AW-1:0] cpu_addr,
  input  logic          cpu_rnw,
  input  logic [DW-1:0] cpu_wdata,
  input  logic [DW-1:0] rd_byte,
  output logic          own_vid,
  output logic          cpu_clk,
  output logic [AW-1:0] addr_q,
  output logic          rnw_q,
  output logic [DW-1:0] wr_byte,
  output logic [DW-1:0] cpu_rdata
);

  logic          own_q;
  logic          clk_q;
  logic [DW-1:0] wr_q;
  logic [DW-1:0] rd_q;

  logic clk_en, rise, fall;
  logic own_en, req_en, wr_en, rd_en;

  always_comb begin
    clk_en = slot_end & ~own_q;
    rise   = clk_en & ~clk_q;
    fall   = clk_en &  clk_q;
    own_en = slot_end;
    req_en = fall;
    wr_en  = rise & ~rnw_q;
    rd_en  = rise &  rnw_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      own_q <= 1'b1;
    else if (own_en) own_q <= vid_own;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      clk_q <= 1'b0;
    else if (clk_en) clk_q <= ~clk_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      rnw_q  <= 1'b1;
    end else if (req_en) begin
      addr_q <= cpu_addr;
      rnw_q  <= cpu_rnw;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     wr_q <= '0;
    else if (wr_en) wr_q <= cpu_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_q <= '0;
    else if (rd_en) rd_q <= rd_byte;
  end

  assign own_vid   = own_q;
  assign cpu_clk   = clk_q;
  assign wr_byte   = wr_q;
  assign cpu_rdata = rd_q;

endmodule

// File: rtl/nibseq_nibble_path.sv
module nibseq_nibble_path
  import nibseq_pkg::*;
#(
  parameter int unsigned NW = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  phase_e          phase,
  input  logic            cap_en,
  input  logic [NW-1:0]   ram_rdata,
  input  logic [2*NW-1:0] wr_byte,
  output logic [2*NW-1:0] rd_byte,
  output logic [NW-1:0]   ram_wdata
);

  localparam int unsigned DW = 2 * NW;

  logic [DW-1:0] asm_q;
  logic [DW-1:0] asm_d;
  logic          asm_en;

  always_comb begin
    asm_en = cap_en & ((phase == PH_HI) | (phase == PH_LO));
    asm_d  = asm_q;
    if (phase == PH_HI) asm_d = {ram_rdata, {NW{1'b0}}};
    else                asm_d = asm_q | {{NW{1'b0}}, ram_rdata};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      asm_q <= '0;
    else if (asm_en) asm_q <= asm_d;
  end

  always_comb begin
    if (phase == PH_LO) ram_wdata = wr_byte[NW-1:0];
    else                ram_wdata = wr_byte[DW-1:NW];
  end

  assign rd_byte = asm_q;

endmodule

// File: rtl/nibram_cpu_seq.sv
module nibram_cpu_seq
  import nibseq_pkg::*;
#(
  parameter int unsigned AW          = 16,
  parameter int unsigned COL_W       = 8,
  parameter int unsigned NW          = 4,
  parameter int unsigned SLOT_LEN    = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  vid_own,
  input  logic [AW-1:0]         vid_addr,
  input  logic [AW-1:0]         cpu_addr,
  input  logic                  cpu_rnw,
  input  logic [2*NW-1:0]       cpu_wdata,
  output logic [2*NW-1:0]       cpu_rdata,
  output logic                  cpu_clk,
  output logic [AW-COL_W:0]     ram_row,
  output logic [COL_W-1:0]      ram_col,
  output logic                  ram_ras_n,
  output logic                  ram_cas_n,
  output logic                  ram_we_n,
  output logic [NW-1:0]         ram_wdata,
  input  logic [NW-1:0]         ram_rdata
);

  localparam int unsigned DW = 2 * NW;
  localparam int unsigned NA = AW + 1;

  // Reset: asserted asynchronously, released through a flop chain.
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_sync_n = sync_q[SYNC_STAGES-1];

  phase_e        phase;
  logic          slot_end;
  logic          own_vid;
  logic [AW-1:0] addr_q;
  logic          rnw_q;
  logic [DW-1:0] wr_byte;
  logic [DW-1:0] rd_byte;

  nibseq_slot_timer #(.SLOT_LEN(SLOT_LEN)) u_timer (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .phase    (phase),
    .slot_end (slot_end)
  );

  nibseq_cpu_phase #(.AW(AW), .DW(DW)) u_cpu (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .slot_end  (slot_end),
    .vid_own   (vid_own),
    .cpu_addr  (cpu_addr),
    .cpu_rnw   (cpu_rnw),
    .cpu_wdata (cpu_wdata),
    .rd_byte   (rd_byte),
    .own_vid   (own_vid),
    .cpu_clk   (cpu_clk),
    .addr_q    (addr_q),
    .rnw_q     (rnw_q),
    .wr_byte   (wr_byte),
    .cpu_rdata (cpu_rdata)
  );

  logic write_slot;
  logic in_access;
  logic cap_en;
  logic half;
  logic [AW-1:0] byte_addr;
  logic [NA-1:0] nib_addr;

  always_comb begin
    write_slot = ~own_vid & cpu_clk & ~rnw_q;
    in_access  = (phase == PH_HI) | (phase == PH_GAP) | (phase == PH_LO);
    cap_en     = ~own_vid & ~write_slot;
    half       = (phase == PH_LO);
    byte_addr  = own_vid ? vid_addr : addr_q;
    nib_addr   = {byte_addr, half};
  end

  nibseq_nibble_path #(.NW(NW)) u_path (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .phase     (phase),
    .cap_en    (cap_en),
    .ram_rdata (ram_rdata),
    .wr_byte   (wr_byte),
    .rd_byte   (rd_byte),
    .ram_wdata (ram_wdata)
  );

  always_comb begin
    ram_row   = nib_addr[NA-1:COL_W];
    ram_col   = nib_addr[COL_W-1:0];
    ram_ras_n = (phase == PH_REST);
    ram_cas_n = ~((phase == PH_HI) | (phase == PH_LO));
    ram_we_n  = ~(write_slot & in_access);
  end

endmodule

// File: rtl/nibseq_checker.sv
module nibseq_checker #(
  parameter int unsigned RW = 9,
  parameter int unsigned CW = 8,
  parameter int unsigned DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ram_ras_n,
  input logic          ram_cas_n,
  input logic          ram_we_n,
  input logic [RW-1:0] ram_row,
  input logic [CW-1:0] ram_col,
  input logic          cpu_clk,
  input logic [DW-1:0] cpu_rdata,
  input logic          own_vid,
  input logic          slot_end
);

  // R1: a column strobe only inside an open row.
  a_r1_cas_inside_ras: assert property (@(posedge clk) disable iff (!rst_n)
    !ram_cas_n |-> !ram_ras_n);

  // R1: each column strobe lasts exactly one cycle.
  a_r1_cas_single: assert property (@(posedge clk) disable iff (!rst_n)
    !ram_cas_n |=> ram_cas_n);

  // R2: the row holds while the row strobe stays low.
  a_r2_row_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!ram_ras_n && !$past(ram_ras_n)) |-> $stable(ram_row));

  // R2: the second column strobe addresses the odd partner of the first.
  a_r2_col_pair: assert property (@(posedge clk) disable iff (!rst_n)
    (!ram_cas_n && !$past(ram_cas_n, 2))
      |-> (ram_col[0] && !$past(ram_col[0], 2)
           && ram_col[CW-1:1] == $past(ram_col[CW-1:1], 2)));

  // R5: a video slot never writes.
  a_r5_video_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    own_vid |-> ram_we_n);

  // R6: writes only while the generated clock is high.
  a_r6_write_clk_high: assert property (@(posedge clk) disable iff (!rst_n)
    !ram_we_n |-> cpu_clk);

  // R7: the generated clock moves only at the end of a processor slot.
  a_r7_clk_at_cpu_slot_end: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_clk != $past(cpu_clk)) |-> ($past(slot_end) && !$past(own_vid)));

  // R8: returned data changes only on a rising generated clock.
  a_r8_rdata_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_rdata != $past(cpu_rdata)) |-> $rose(cpu_clk));

endmodule

bind nibram_cpu_seq nibseq_checker #(
  .RW (AW + 1 - COL_W),
  .CW (COL_W),
  .DW (2 * NW)
) u_nibseq_checker (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .ram_ras_n (ram_ras_n),
  .ram_cas_n (ram_cas_n),
  .ram_we_n  (ram_we_n),
  .ram_row   (ram_row),
  .ram_col   (ram_col),
  .cpu_clk   (cpu_clk),
  .cpu_rdata (cpu_rdata),
  .own_vid   (own_vid),
  .slot_end  (slot_end)
);

// File: tb/nibram_cpu_seq_bench.sv
module nibram_cpu_seq_bench;

  localparam int unsigned AW       = 10;
  localparam int unsigned COL_W    = 8;
  localparam int unsigned NW       = 4;
  localparam int unsigned SLOT_LEN = 8;
  localparam int unsigned DW       = 2 * NW;
  localparam int unsigned NA       = AW + 1;
  localparam int unsigned RW       = NA - COL_W;
  localparam int unsigned MEMN     = 1 << NA;

  logic          clk;
  logic          rst_n;
  logic          vid_own;
  logic [AW-1:0] vid_addr;
  logic [AW-1:0] cpu_addr;
  logic          cpu_rnw;
  logic [DW-1:0] cpu_wdata;
  logic [DW-1:0] cpu_rdata;
  logic          cpu_clk;
  logic [RW-1:0] ram_row;
  logic [COL_W-1:0] ram_col;
  logic          ram_ras_n, ram_cas_n, ram_we_n;
  logic [NW-1:0] ram_wdata, ram_rdata;

  nibram_cpu_seq #(.AW(AW), .COL_W(COL_W), .NW(NW), .SLOT_LEN(SLOT_LEN),
                   .SYNC_STAGES(2)) u_nibram_cpu_seq (
    .clk(clk), .rst_n(rst_n), .vid_own(vid_own), .vid_addr(vid_addr),
    .cpu_addr(cpu_addr), .cpu_rnw(cpu_rnw), .cpu_wdata(cpu_wdata),
    .cpu_rdata(cpu_rdata), .cpu_clk(cpu_clk), .ram_row(ram_row),
    .ram_col(ram_col), .ram_ras_n(ram_ras_n), .ram_cas_n(ram_cas_n),
    .ram_we_n(ram_we_n), .ram_wdata(ram_wdata), .ram_rdata(ram_rdata)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [NW-1:0] init_nib(int i);
    return NW'((i * 7 + 3) % 16);
  endfunction

  // Nibble memory model: combinational read, write on a strobed cycle.
  logic [NW-1:0] mem [MEMN];
  logic [NA-1:0] m_idx;
  assign m_idx     = {ram_row, ram_col};
  assign ram_rdata = mem[m_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < MEMN; i++) mem[i] <= init_nib(i);
    end else if (!ram_ras_n && !ram_cas_n && !ram_we_n) begin
      mem[m_idx] <= ram_wdata;
    end
  end

  // Expected image, byte-level view: high nibble even, low nibble odd.
  logic [NW-1:0] exp_m [MEMN];
  function automatic logic [DW-1:0] exp_byte(logic [AW-1:0] a);
    return {exp_m[{a, 1'b0}], exp_m[{a, 1'b1}]};
  endfunction

  int checks, errors;
  int mon_chk, mon_err;
  int vid_pct;
  bit done;

  // Slot monitor: draws ownership, checks clock motion and video slots.
  logic prev_ras, started, cur_own, drv_own, clk_at_start;
  int   cas_cnt;
  always @(negedge clk) begin
    if (!rst_n) begin
      prev_ras = 1'b1; started = 1'b0; cur_own = 1'b1; drv_own = 1'b1;
      clk_at_start = 1'b0; cas_cnt = 0; mon_chk = 0; mon_err = 0;
      vid_own = 1'b1; vid_addr = '0;
    end else begin
      if (prev_ras && !ram_ras_n) begin
        if (started) begin
          mon_chk++;
          if ((cpu_clk != clk_at_start) != !cur_own) begin
            mon_err++;
            $display("FAIL R7 clock toggle after slot (video=%0d): got %0d exp %0d",
                     cur_own, cpu_clk != clk_at_start, !cur_own);
          end
        end
        started      = 1'b1;
        clk_at_start = cpu_clk;
        cur_own      = drv_own;
        drv_own      = (($urandom % 100) < vid_pct);
        vid_own      = drv_own;
        vid_addr     = AW'($urandom);
        cas_cnt      = 0;
      end
      if (started && !ram_cas_n && cur_own) begin
        mon_chk++;
        if ({ram_row, ram_col} != {vid_addr, cas_cnt[0]} || !ram_we_n) begin
          mon_err++;
          $display("FAIL R5 video cas %0d: addr %h we_n %b exp addr %h we_n 1",
                   cas_cnt, {ram_row, ram_col}, ram_we_n, {vid_addr, cas_cnt[0]});
        end
      end
      if (!ram_cas_n) cas_cnt++;
      prev_ras = ram_ras_n;
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, expv);
    end
  endtask

  // One processor transaction, starting with cpu_clk high.
  task automatic txn(input logic [AW-1:0] a, input logic rnw,
                     input logic [DW-1:0] d, input bit scramble, input string req);
    while (cpu_clk !== 1'b1) @(negedge clk);
    cpu_addr = a; cpu_rnw = rnw; cpu_wdata = d;
    while (cpu_clk !== 1'b0) @(negedge clk);
    if (scramble) begin
      cpu_addr = AW'($urandom);
      cpu_rnw  = 1'($urandom);
    end
    while (cpu_clk !== 1'b1) @(negedge clk);
    if (rnw) check(cpu_rdata == exp_byte(a), req, 32'(cpu_rdata), 32'(exp_byte(a)));
    else begin
      exp_m[{a, 1'b0}] = d[DW-1:NW];
      exp_m[{a, 1'b1}] = d[NW-1:0];
    end
  endtask

  initial begin
    checks = 0; errors = 0; done = 1'b0; vid_pct = 0;
    rst_n = 1'b0; cpu_addr = '0; cpu_rnw = 1'b1; cpu_wdata = '0;
    void'($urandom(32'h5eed1234));
    for (int i = 0; i < MEMN; i++) exp_m[i] = init_nib(i);
    repeat (4) @(negedge clk);
    // R10: reset state at the ports.
    check(cpu_clk == 1'b0, "R10 cpu_clk in reset", 32'(cpu_clk), 0);
    check(ram_ras_n && ram_cas_n, "R10 strobes in reset", {ram_ras_n, ram_cas_n}, 3);
    check(ram_we_n == 1'b1, "R10 we_n in reset", 32'(ram_we_n), 1);
    rst_n = 1'b1;
    // R10: first rising clock delivers address 0 (latched read at reset).
    while (cpu_clk !== 1'b1) @(negedge clk);
    check(cpu_rdata == exp_byte('0), "R10 first byte", 32'(cpu_rdata), 32'(exp_byte('0)));
    // R4: nibble order of untouched locations.
    txn(10'd5, 1'b1, 8'h00, 1'b0, "R4 read assemble addr 5");
    txn(10'd1023, 1'b1, 8'h00, 1'b0, "R4 read assemble top addr");
    // R3: directed writes with distinct nibbles, then readback.
    txn(10'd0, 1'b0, 8'hA5, 1'b0, "R3");
    txn(10'd1023, 1'b0, 8'h3C, 1'b0, "R3");
    txn(10'd0, 1'b1, 8'h00, 1'b0, "R3 readback addr 0");
    txn(10'd1023, 1'b1, 8'h00, 1'b0, "R3 readback top addr");
    txn(10'd5, 1'b0, 8'hF0, 1'b0, "R3");
    txn(10'd5, 1'b1, 8'h00, 1'b0, "R3 readback F0");
    // R9: inputs scrambled after the fall must not matter.
    txn(10'd9, 1'b0, 8'h96, 1'b1, "R9");
    txn(10'd9, 1'b1, 8'h00, 1'b1, "R9 scrambled read");
    // R5/R7: heavy video load.
    vid_pct = 90;
    txn(10'd7, 1'b0, 8'h0F, 1'b1, "R5");
    txn(10'd7, 1'b1, 8'h00, 1'b1, "R5 read under video load");
    // Random mix (R3, R6, R8, R9).
    vid_pct = 50;
    for (int n = 0; n < 300; n++) begin
      logic [AW-1:0] a;
      logic          rw;
      a  = ((n % 7) == 0) ? AW'($urandom) : AW'($urandom % 64);
      rw = 1'($urandom);
      txn(a, rw, DW'($urandom), 1'b1, "R8 random read");
    end
    // R7: all-video stretch holds the generated clock.
    vid_pct = 100;
    repeat (3 * SLOT_LEN) @(negedge clk);
    begin
      logic held;
      held = cpu_clk;
      repeat (20 * SLOT_LEN) @(negedge clk);
      check(cpu_clk == held, "R7 clock held across video slots", 32'(cpu_clk), 32'(held));
    end
    vid_pct = 0;
    txn(10'd3, 1'b1, 8'h00, 1'b0, "R6 read after video stretch");
    txn(10'd3, 1'b1, 8'h00, 1'b0, "R6 read after video stretch");
    // R5/R6: no stray writes anywhere in memory.
    begin
      int bad;
      bad = 0;
      for (int i = 0; i < MEMN; i++) if (mem[i] != exp_m[i]) bad++;
      check(bad == 0, "R5 R6 memory image mismatches", 32'(bad), 0);
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors + mon_err, checks + mon_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors + mon_err + 1, checks + mon_chk + 1);
      $finish;
    end
  end

endmodule